// File: doc/BRIEF.md
# Windowed Serial-Flash Read Engine

This block serves reads from a 64 MB memory window out of an external serial flash. A requester presents a word index inside the window. The engine first looks in a one-line read cache. On a hit it answers from the cache at once. On a miss it asks the serial sequencer for a burst of words, stores the words in the line, and returns the requested word when the burst is complete.

Software programs the transaction setup ahead of time through a small configuration write port. The setup covers the opcode pair, option bytes, phase enables, dummy cycles, burst shape, chip-select release and extended address bits. The sequencer receives this setup along with each fetch.

Up to four extended-address bits can replace flash byte-address bits from bit 25 upward. This lets the window reach any 64 MB region of a larger device. Any configuration write empties the cache, so data fetched under an old setup is never served again.

Top module: `flash_window_reader`

## Requirements
- R1: After reset, rd_valid and seq_req are low, bursts are off, no extended bits are in use, seq_dummy is 1 and seq_cs_release is 0.
- R2: The flash byte address is {rd_word, 2'b00} zero-extended to 32 bits, then adjusted for extended bits. With an extended count k (field value min(cfg[10:8], 4) of the extended register, select 2), byte bits 25 to 25+k-1 take extended value bits [k-1:0] (cfg[3:0]). When k is 0, bit 25 keeps the window offset bit.
- R3: A miss raises seq_req, with seq_addr set to the flash byte address of the requested word, and holds it until seq_ack. rd_valid pulses one cycle after the last data beat, and rd_data then carries the first beat.
- R4: The number of words fetched is 1 when bursts are off (control bit 1 clear, select 0). When bursts are on, it is min(field+1, LINE_WORDS - word position in line), where field is control bits [12:8] and holds the length minus one.
- R5: A request for a word that the current line holds produces rd_valid, with that word, one cycle after the request is seen, and raises no seq_req.
- R6: A miss to a different line (tag = flash word address above the line index) drops every word the line held before.
- R7: A write of control with bit 0 (flush) set empties the cache. So does a write to any other mapped select (0 to 5).
- R8: If a configuration write lands while a fetch is in flight, none of that fetch's words are kept in the cache. The requester still receives its word.
- R9: seq_dummy equals the dummy register (select 5, bits [4:0]) plus one.
- R10: seq_phases carries the phase register (select 4) with bits [3:0] forced to zero. seq_opcode carries select 1 bits [15:0], and seq_option carries select 3.
- R11: seq_cs_release follows control bit 2.
- R12: rd_valid lasts one cycle. A request still present in the cycle where rd_valid is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 opcode, 2 extended, 3 option, 4 phases, 5 dummy) |
| cfg_wdata | input | 32 | Configuration write data |
| rd_req | input | 1 | Read request, held until rd_valid |
| rd_word | input | 24 | Word index inside the 64 MB window |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | 32 | Read response data |
| seq_req | output | 1 | Fetch request to the sequencer |
| seq_addr | output | 32 | Flash byte address of the first word |
| seq_words | output | 4 | Number of words to fetch |
| seq_opcode | output | 16 | Opcode pair |
| seq_option | output | 32 | Option bytes |
| seq_phases | output | 32 | Phase enable word, data nibble cleared |
| seq_dummy | output | 6 | Dummy cycle count |
| seq_cs_release | output | 1 | Release chip select after each burst |
| seq_ack | input | 1 | Sequencer accepts the fetch |
| seq_rvalid | input | 1 | Fetch data beat strobe |
| seq_rdata | input | 32 | Fetch data beat |

## Verification
The bench targets bursts that would run past the end of the line, where a design that ignored the clip would fetch the wrong number of words and write into the wrong slots. It switches the extended count through 0, 1, 2 and an out-of-range code. A wrong substitution would show up as a wrong seq_addr and as a wrong tag, so words from the wrong region would hit.

It writes configuration while a fill is in flight. A design that kept that fill would return stale data on the next read instead of fetching again. It also holds the request into the response cycle. A design that did not ignore it would answer twice or start a second fetch.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    localparam int BURST_W = 5;
    localparam int EXT_CNT_W = 3;
    localparam int DUMMY_W = 5;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_OPCODE = 3'd1,
        SEL_EXT    = 3'd2,
        SEL_OPTION = 3'd3,
        SEL_PHASE  = 3'd4,
        SEL_DUMMY  = 3'd5
    } cfg_sel_e;

    typedef struct packed {
        logic                 burst_en;
        logic                 cs_release;
        logic [BURST_W-1:0]   burst_m1;
        logic [15:0]          opcode;
        logic [3:0]           ext_val;
        logic [EXT_CNT_W-1:0] ext_cnt;
        logic [31:0]          option;
        logic [31:0]          phases;
        logic [DUMMY_W-1:0]   dummy_m1;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FILL  = 2'd2
    } fsm_e;

endpackage

// File: rtl/fxr_cfg_regs.sv
module fxr_cfg_regs
    import fxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_i,
    input  logic [2:0]  sel_i,
    input  logic [31:0] wdata_i,
    output cfg_t        cfg_o,
    output logic        inval_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d   = cfg_q;
        inval_o = 1'b0;
        if (we_i) begin
            inval_o = 1'b1;
            case (cfg_sel_e'(sel_i))
                SEL_CTRL: begin
                    // bit 0 is the flush request; the write itself empties the cache
                    cfg_d.burst_en   = wdata_i[1];
                    cfg_d.cs_release = wdata_i[2];
                    cfg_d.burst_m1   = wdata_i[8 +: BURST_W];
                end
                SEL_OPCODE: cfg_d.opcode = wdata_i[15:0];
                SEL_EXT: begin
                    cfg_d.ext_val = wdata_i[3:0];
                    cfg_d.ext_cnt = wdata_i[8 +: EXT_CNT_W];
                end
                SEL_OPTION: cfg_d.option = wdata_i;
                // data-enable nibble is not kept
                SEL_PHASE:  cfg_d.phases = {wdata_i[31:4], 4'b0000};
                SEL_DUMMY:  cfg_d.dummy_m1 = wdata_i[DUMMY_W-1:0];
                default:    inval_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R10
    phase_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == 3'd4) |=> (cfg_q.phases[3:0] == 4'b0000));

endmodule

// File: rtl/fxr_addr_xlate.sv
module fxr_addr_xlate #(
    parameter int WIN_BITS = 26,
    parameter int EXT_BITS = 4,
    parameter int ADDR_W   = 32,
    localparam int WW      = WIN_BITS - 2,
    localparam int AW      = ADDR_W - 2,
    localparam int TOPW    = WW - 1 + EXT_BITS,
    localparam int ZW      = AW - TOPW
) (
    input  logic [WW-1:0]       word_i,
    input  logic [EXT_BITS-1:0] ext_val_i,
    input  logic [2:0]          ext_cnt_i,
    output logic [AW-1:0]       waddr_o
);

    logic [2:0]          k;
    logic [EXT_BITS-1:0] hi;

    assign k = (int'(ext_cnt_i) > EXT_BITS) ? 3'(EXT_BITS) : ext_cnt_i;

    for (genvar g = 0; g < EXT_BITS; g++) begin : g_ext
        if (g == 0) begin : g_low
            assign hi[g] = (int'(k) > g) ? ext_val_i[g] : word_i[WW-1];
        end else begin : g_up
            assign hi[g] = (int'(k) > g) ? ext_val_i[g] : 1'b0;
        end
    end

    assign waddr_o = {{ZW{1'b0}}, hi, word_i[WW-2:0]};

endmodule

// File: rtl/fxr_line_buf.sv
module fxr_line_buf #(
    parameter int LINE_WORDS = 8,
    parameter int TAG_W      = 27,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             alloc_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [31:0]      wr_data_i,
    input  logic [TAG_W-1:0] lk_tag_i,
    input  logic [IDX_W-1:0] lk_idx_i,
    output logic             hit_o,
    output logic [31:0]      rdata_o
);

    typedef struct packed {
        logic [TAG_W-1:0]                 tag;
        logic [LINE_WORDS-1:0]            valid;
        logic [LINE_WORDS-1:0][31:0]      data;
    } line_t;

    line_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (alloc_i) begin
            if (alloc_tag_i != s_q.tag) s_d.valid = '0;
            s_d.tag = alloc_tag_i;
        end
        if (wr_en_i) begin
            s_d.data[wr_idx_i]  = wr_data_i;
            s_d.valid[wr_idx_i] = 1'b1;
        end
        if (clear_i) s_d.valid = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o   = s_q.valid[lk_idx_i] && (s_q.tag == lk_tag_i);
    assign rdata_o = s_q.data[lk_idx_i];

    // R7
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (s_q.valid == '0));

    // R6
    alloc_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && (alloc_tag_i != s_q.tag) && !wr_en_i) |=> (s_q.valid == '0));

endmodule

// File: rtl/fxr_fetch_fsm.sv
module fxr_fetch_fsm
    import fxr_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int AW         = 30,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int CNT_W     = IDX_W + 1,
    localparam int N_W       = BURST_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic               burst_en_i,
    input  logic [BURST_W-1:0] burst_m1_i,
    input  logic               inval_i,
    input  logic               hit_i,
    input  logic [31:0]        hit_data_i,
    output logic               rd_valid_o,
    output logic [31:0]        rd_data_o,
    output logic               seq_req_o,
    output logic [AW-1:0]      seq_waddr_o,
    output logic [CNT_W-1:0]   seq_words_o,
    input  logic               seq_ack_i,
    input  logic               seq_rvalid_i,
    input  logic [31:0]        seq_rdata_i,
    output logic               alloc_o,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o
);

    typedef struct packed {
        fsm_e             st;
        logic [AW-1:0]    waddr;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] beat;
        logic             stale;
        logic             rvld;
        logic [31:0]      rdata;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [CNT_W-1:0] room;
    logic [N_W-1:0]   want;
    logic [CNT_W-1:0] words;

    always_comb begin
        room  = CNT_W'(LINE_WORDS) - {1'b0, waddr_i[IDX_W-1:0]};
        want  = burst_en_i ? ({1'b0, burst_m1_i} + N_W'(1)) : N_W'(1);
        words = (want < N_W'(room)) ? CNT_W'(want) : room;
    end

    always_comb begin
        s_d      = s_q;
        s_d.rvld = 1'b0;
        alloc_o  = 1'b0;
        wr_en_o  = 1'b0;
        wr_idx_o = s_q.waddr[IDX_W-1:0] + s_q.beat[IDX_W-1:0];
        if (inval_i) s_d.stale = 1'b1;
        case (s_q.st)
            ST_IDLE: begin
                if (rd_req_i && !s_q.rvld) begin
                    if (hit_i) begin
                        s_d.rvld  = 1'b1;
                        s_d.rdata = hit_data_i;
                    end else begin
                        alloc_o   = 1'b1;
                        s_d.waddr = waddr_i;
                        s_d.cnt   = words;
                        s_d.beat  = '0;
                        s_d.stale = inval_i;
                        s_d.st    = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (seq_ack_i) s_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (seq_rvalid_i) begin
                    wr_en_o = !s_q.stale;
                    if (s_q.beat == '0) s_d.rdata = seq_rdata_i;
                    if (s_q.beat == s_q.cnt - CNT_W'(1)) begin
                        s_d.rvld = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.beat = s_q.beat + CNT_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid_o  = s_q.rvld;
    assign rd_data_o   = s_q.rdata;
    assign seq_req_o   = (s_q.st == ST_ISSUE);
    assign seq_waddr_o = s_q.waddr;
    assign seq_words_o = s_q.cnt;

    // R3
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req_o && !seq_ack_i) |=> (seq_req_o && $stable(seq_waddr_o)));

    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    // R4
    words_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req_o |-> (seq_words_o != '0 && int'(seq_words_o) <= LINE_WORDS));

    // R4
    fill_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILL) |-> (s_q.beat < s_q.cnt));

    // R5
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && rd_req_i && !s_q.rvld && hit_i) |=> (!seq_req_o && rd_valid_o));

    // R8
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stale && s_q.st == ST_FILL) |-> !wr_en_o);

endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader
    import fxr_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int WIN_BITS   = 26,
    parameter int EXT_BITS   = 4,
    parameter int ADDR_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [2:0]                      cfg_sel,
    input  logic [31:0]                     cfg_wdata,
    input  logic                            rd_req,
    input  logic [WIN_BITS-3:0]             rd_word,
    output logic                            rd_valid,
    output logic [31:0]                     rd_data,
    output logic                            seq_req,
    output logic [ADDR_W-1:0]               seq_addr,
    output logic [$clog2(LINE_WORDS):0]     seq_words,
    output logic [15:0]                     seq_opcode,
    output logic [31:0]                     seq_option,
    output logic [31:0]                     seq_phases,
    output logic [DUMMY_W:0]                seq_dummy,
    output logic                            seq_cs_release,
    input  logic                            seq_ack,
    input  logic                            seq_rvalid,
    input  logic [31:0]                     seq_rdata
);

    localparam int IDX_W = $clog2(LINE_WORDS);
    localparam int AW    = ADDR_W - 2;
    localparam int TAG_W = AW - IDX_W;

    cfg_t             cfg;
    logic             inval;
    logic [AW-1:0]    xl_waddr;
    logic [AW-1:0]    fetch_waddr;
    logic             hit;
    logic [31:0]      hit_data;
    logic             alloc;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    fxr_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg),
        .inval_o (inval)
    );

    fxr_addr_xlate #(
        .WIN_BITS (WIN_BITS),
        .EXT_BITS (EXT_BITS),
        .ADDR_W   (ADDR_W)
    ) u_xlate (
        .word_i    (rd_word),
        .ext_val_i (cfg.ext_val[EXT_BITS-1:0]),
        .ext_cnt_i (cfg.ext_cnt),
        .waddr_o   (xl_waddr)
    );

    fxr_line_buf #(
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W)
    ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (inval),
        .alloc_i     (alloc),
        .alloc_tag_i (xl_waddr[AW-1:IDX_W]),
        .wr_en_i     (wr_en),
        .wr_idx_i    (wr_idx),
        .wr_data_i   (seq_rdata),
        .lk_tag_i    (xl_waddr[AW-1:IDX_W]),
        .lk_idx_i    (xl_waddr[IDX_W-1:0]),
        .hit_o       (hit),
        .rdata_o     (hit_data)
    );

    fxr_fetch_fsm #(
        .LINE_WORDS (LINE_WORDS),
        .AW         (AW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_i     (rd_req),
        .waddr_i      (xl_waddr),
        .burst_en_i   (cfg.burst_en),
        .burst_m1_i   (cfg.burst_m1),
        .inval_i      (inval),
        .hit_i        (hit),
        .hit_data_i   (hit_data),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data),
        .seq_req_o    (seq_req),
        .seq_waddr_o  (fetch_waddr),
        .seq_words_o  (seq_words),
        .seq_ack_i    (seq_ack),
        .seq_rvalid_i (seq_rvalid),
        .seq_rdata_i  (seq_rdata),
        .alloc_o      (alloc),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx)
    );

    assign seq_addr       = {fetch_waddr, 2'b00};
    assign seq_opcode     = cfg.opcode;
    assign seq_option     = cfg.option;
    assign seq_phases     = cfg.phases;
    assign seq_dummy      = {1'b0, cfg.dummy_m1} + (DUMMY_W+1)'(1);
    assign seq_cs_release = cfg.cs_release;

    // R9
    dummy_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_dummy != '0);

endmodule

// File: tb/flash_window_reader_tb.sv
module flash_window_reader_tb_top;

    localparam int LW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rd_req = 1'b0;
    logic [23:0] rd_word = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        seq_req;
    logic [31:0] seq_addr;
    logic [3:0]  seq_words;
    logic [15:0] seq_opcode;
    logic [31:0] seq_option;
    logic [31:0] seq_phases;
    logic [5:0]  seq_dummy;
    logic        seq_cs_release;
    logic        seq_ack = 1'b0;
    logic        seq_rvalid = 1'b0;
    logic [31:0] seq_rdata = '0;

    always #4 clk = ~clk;

    flash_window_reader dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_req(rd_req), .rd_word(rd_word), .rd_valid(rd_valid), .rd_data(rd_data),
        .seq_req(seq_req), .seq_addr(seq_addr), .seq_words(seq_words), .seq_opcode(seq_opcode),
        .seq_option(seq_option), .seq_phases(seq_phases), .seq_dummy(seq_dummy),
        .seq_cs_release(seq_cs_release), .seq_ack(seq_ack), .seq_rvalid(seq_rvalid),
        .seq_rdata(seq_rdata)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit         b_burst = 0;
    bit         b_cs = 0;
    logic [4:0] b_m1 = '0;
    logic [3:0] b_extv = '0;
    logic [2:0] b_extc = '0;
    logic [4:0] b_dummy = '0;

    logic [LW-1:0] m_valid = '0;
    logic [26:0]   m_tag = '0;
    bit            last_miss;

    function automatic logic [31:0] fdata(input logic [31:0] a);
        return a ^ {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] xl(input logic [23:0] w);
        logic [31:0] a;
        int k;
        a = {6'd0, w, 2'b00};
        k = (int'(b_extc) > 4) ? 4 : int'(b_extc);
        for (int i = 0; i < k; i++) a[25+i] = b_extv[i];
        return a;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel <= 3'd5) m_valid = '0;
    endtask

    task automatic wr_ctrl(input bit flush);
        cfg_write(3'd0, {19'd0, b_m1, 5'd0, b_cs, b_burst, flush});
    endtask

    task automatic wr_ext();
        cfg_write(3'd2, {21'd0, b_extc, 4'd0, b_extv});
    endtask

    task automatic do_read(input logic [23:0] w, input bit inject);
        logic [31:0] fa, got, saddr;
        logic [26:0] tg;
        int idx, n, ew, words, lat;
        bit exp_hit, miss, got_v;
        fa = xl(w);
        tg = fa[31:5];
        idx = int'(fa[4:2]);
        exp_hit = m_valid[idx] && (m_tag == tg);
        n = b_burst ? int'(b_m1) + 1 : 1;
        ew = (n < LW - idx) ? n : LW - idx;
        miss = 0; got_v = 0; words = 0; saddr = '0; got = '0; lat = 0;
        rd_word = w; rd_req = 1'b1;
        for (int t = 0; t < 100 && !got_v; t++) begin
            @(negedge clk);
            lat = t;
            if (rd_valid) begin
                got_v = 1; got = rd_data;
            end else if (seq_req) begin
                miss = 1; saddr = seq_addr; words = int'(seq_words);
                seq_ack = 1'b1;
                @(negedge clk);
                seq_ack = 1'b0;
                for (int b = 0; b < words; b++) begin
                    seq_rvalid = 1'b1;
                    seq_rdata = fdata(saddr + 32'(4 * b));
                    if (inject && b == 0) begin
                        cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = {27'd0, b_dummy};
                    end
                    @(negedge clk);
                    cfg_we = 1'b0;
                end
                seq_rvalid = 1'b0;
                if (rd_valid) begin got_v = 1; got = rd_data; end
            end
        end
        last_miss = miss;
        check(got_v, "R3 R5 response", 32'(got_v), 32'd1);
        check(miss == !exp_hit, "R5 R6 R7 hit/miss", 32'(miss), 32'(!exp_hit));
        check(got == fdata(fa), "R3 R5 R8 data", got, fdata(fa));
        if (miss && !exp_hit) begin
            check(saddr == fa, "R2 R3 fetch address", saddr, fa);
            check(words == ew, "R4 fetch words", 32'(words), 32'(ew));
        end
        if (!miss && exp_hit) check(lat == 0, "R5 hit latency", 32'(lat), 32'd0);
        // R12: request still high during the response cycle must be ignored
        @(negedge clk);
        check(!rd_valid && !seq_req, "R12 single response", {30'd0, rd_valid, seq_req}, 32'd0);
        rd_req = 1'b0;
        if (!exp_hit) begin
            if (tg != m_tag) m_valid = '0;
            m_tag = tg;
            if (inject) m_valid = '0;
            else for (int i = idx; i < idx + ew; i++) m_valid[i] = 1'b1;
        end
    endtask

    initial begin
        int unsigned sd;
        logic [23:0] bases [4];
        sd = $urandom(32'd20240611);
        bases[0] = 24'h00_0040; bases[1] = 24'h80_0010;
        bases[2] = 24'h7F_FFF0; bases[3] = 24'h12_3450;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!rd_valid && !seq_req, "R1 reset outputs", {30'd0, rd_valid, seq_req}, 32'd0);
        check(seq_dummy == 6'd1, "R1 R9 reset dummy", 32'(seq_dummy), 32'd1);
        check(!seq_cs_release, "R1 R11 reset release", 32'(seq_cs_release), 32'd0);
        do_read(24'h80_0003, 1'b0);
        check(last_miss, "R1 first read misses", 32'(last_miss), 32'd1);

        // R9 R10 R11
        b_dummy = 5'd9; cfg_write(3'd5, 32'h0000_0009);
        check(seq_dummy == 6'd10, "R9 dummy plus one", 32'(seq_dummy), 32'd10);
        cfg_write(3'd4, 32'hFFFF_FFFF);
        check(seq_phases == 32'hFFFF_FFF0, "R10 phase nibble", seq_phases, 32'hFFFF_FFF0);
        cfg_write(3'd1, 32'h0000_EB13);
        check(seq_opcode == 16'hEB13, "R10 opcode", 32'(seq_opcode), 32'h0000_EB13);
        cfg_write(3'd3, 32'hCAFE_0001);
        check(seq_option == 32'hCAFE_0001, "R10 option", seq_option, 32'hCAFE_0001);
        b_cs = 1; wr_ctrl(1'b0);
        check(seq_cs_release, "R11 release set", 32'(seq_cs_release), 32'd1);
        b_cs = 0; wr_ctrl(1'b0);
        check(!seq_cs_release, "R11 release clear", 32'(seq_cs_release), 32'd0);

        // R2 extended bits
        b_extv = 4'b1010;
        b_extc = 3'd0; wr_ext(); do_read(24'h80_0010, 1'b0);
        b_extc = 3'd1; wr_ext(); do_read(24'h80_0010, 1'b0);
        b_extc = 3'd2; wr_ext(); do_read(24'h80_0010, 1'b0);
        b_extc = 3'd7; wr_ext(); do_read(24'h80_0010, 1'b0);
        check(xl(24'h80_0010) == 32'h1400_0040, "R2 bench map", xl(24'h80_0010), 32'h1400_0040);
        b_extc = 3'd0; wr_ext();

        // R4 bursts clipped at line end
        b_burst = 1; b_m1 = 5'd31; wr_ctrl(1'b0);
        do_read(24'h00_0103, 1'b0);
        do_read(24'h00_0106, 1'b0);
        check(!last_miss, "R4 R5 burst filled tail", 32'(last_miss), 32'd0);
        do_read(24'h00_0101, 1'b0);
        b_m1 = 5'd1; wr_ctrl(1'b0);
        do_read(24'h00_0200, 1'b0);
        do_read(24'h00_0201, 1'b0);
        do_read(24'h00_0202, 1'b0);
        check(last_miss, "R4 two word burst", 32'(last_miss), 32'd1);

        // R7 flush and any write
        do_read(24'h00_0202, 1'b0);
        check(!last_miss, "R7 before flush", 32'(last_miss), 32'd0);
        wr_ctrl(1'b1);
        do_read(24'h00_0202, 1'b0);
        check(last_miss, "R7 after flush", 32'(last_miss), 32'd1);
        cfg_write(3'd3, 32'h1234_5678);
        do_read(24'h00_0202, 1'b0);
        check(last_miss, "R7 after option write", 32'(last_miss), 32'd1);

        // R6 replacement
        do_read(24'h00_0300, 1'b0);
        do_read(24'h00_0202, 1'b0);
        check(last_miss, "R6 other line evicted", 32'(last_miss), 32'd1);

        // R8 write during fill
        b_m1 = 5'd7; wr_ctrl(1'b0);
        do_read(24'h00_0400, 1'b1);
        do_read(24'h00_0400, 1'b0);
        check(last_miss, "R8 fill not kept", 32'(last_miss), 32'd1);
        do_read(24'h00_0405, 1'b0);
        check(!last_miss, "R8 refill kept", 32'(last_miss), 32'd0);

        // random mix
        for (int r = 0; r < 250; r++) begin
            if (($urandom % 12) == 0) begin
                if ($urandom % 2) begin
                    b_burst = 1'($urandom); b_m1 = 5'($urandom); b_cs = 1'($urandom);
                    wr_ctrl(1'($urandom));
                end else begin
                    b_extv = 4'($urandom); b_extc = 3'($urandom);
                    wr_ext();
                end
            end
            do_read(bases[$urandom % 4] + 24'($urandom % 16), ($urandom % 25) == 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R3 actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule